// File: doc/BRIEF.md
# Replicated-Bank Multiport Register File

This block is the integer register file for a dual-issue in-order core: 32 registers of 32 bits, two write ports and four operand read ports, plus an optional fifth read port for a debugger. Every port works at the pipeline clock. There is no faster clock and no time-sharing of a memory between ports.

Ports are multiplied by replication. Each write port owns a row of simple one-read/one-write banks, with one bank per read port. All banks in a row share the same write inputs. A 32-entry, one-bit live-value table remembers which write port last wrote each register. For each read port, a mux picks the bank in the row that the table names.

Inside a bank, a write becomes readable two cycles after it is presented. A bypass compares each read address against the write addresses of the current cycle and of the previous cycle. It returns the youngest matching data, so the latency is not visible at the ports. Read data is combinational from the read address.

Top module: `regFileMp`

## Requirements
- R1: After reset, every register reads zero on every read port.
- R2: Register 0 always reads zero, and a write to it from either port is discarded.
- R3: A read whose address matches an enabled write in the same cycle returns that write's data in that cycle (write-through).
- R4: Data written in a cycle is returned by a read of that register in the next cycle and in every later cycle, until the register is written again.
- R5: Two enabled writes to different registers in the same cycle are both stored.
- R6: If both write ports write the same register in one cycle, write port 1 wins. This holds for the same-cycle read and for all later reads.
- R7: The four operand read ports and the debug read port each return the current value of their own address independently, in the same cycle.
- R8: When a register is written in consecutive cycles, by the same port or by different ports, reads return the most recent write.
- R9: A write port whose enable is low changes no register, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 2 | Write enables; bit 1 is the younger instruction |
| wrAddr | input | 2x5 | Write addresses, one per write port |
| wrData | input | 2x32 | Write data, one per write port |
| rdAddr | input | 4x5 | Operand read addresses |
| rdData | output | 4x32 | Operand read data |
| dbgAddr | input | 5 | Debug read address |
| dbgData | output | 32 | Debug read data; zero when the debug port is not built |

## Verification
Some internal faults are hidden at first. A stale live-value entry, or a bank row that missed a write, is covered by the bypass for two cycles. It shows up on the read ports in the third cycle after the write, as data from the older writer or as zero.

A wrong bypass priority shows up at once, in the same cycle or the next. This happens on same-register collisions between the two write ports, or on back-to-back rewrites of one register.

The bench therefore compares every read port against a behavioural model on every cycle. It uses a narrow random address range so that collisions and rewrites are frequent.

// File: rtl/rfPkg.sv
package rfPkg;
  localparam int WR_PORTS = 2;

  typedef enum logic [2:0] {
    SEL_BANK,
    SEL_ZERO,
    SEL_CUR0,
    SEL_CUR1,
    SEL_PRV0,
    SEL_PRV1
  } srcSel_t;

  typedef struct packed {
    srcSel_t src;
    logic    row;
  } rdCtl_t;

  typedef struct packed {
    logic [WR_PORTS-1:0] cur;
    logic [WR_PORTS-1:0] prv;
  } wrStb_t;
endpackage

// File: rtl/rfBank.sv
module rfBank #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic          weQ;
  logic [AW-1:0] waQ;
  logic [DW-1:0] wdQ;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ <= 1'b0;
      waQ <= '0;
      wdQ <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      weQ <= we;
      waQ <= wa;
      wdQ <= wd;
      if (weQ) mem[waQ] <= wdQ;
    end
  end

  assign rd = mem[ra];
endmodule

// File: rtl/rfControl.sv
module rfControl
  import rfPkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int RD_PORTS = 5,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [WR_PORTS-1:0]           wrEn,
  input  logic [WR_PORTS-1:0][AW-1:0]   wrAddr,
  input  logic [RD_PORTS-1:0][AW-1:0]   rdAddr,
  output wrStb_t                        stb,
  output rdCtl_t [RD_PORTS-1:0]         rdCtl
);
  logic [WR_PORTS-1:0]         curGo;
  logic [WR_PORTS-1:0]         prvGo;
  logic [WR_PORTS-1:0][AW-1:0] prvAddr;
  logic [DEPTH-1:0]            lvt;

  always_comb begin
    curGo[1] = wrEn[1] && (wrAddr[1] != '0);
    curGo[0] = wrEn[0] && (wrAddr[0] != '0) &&
               !(curGo[1] && (wrAddr[1] == wrAddr[0]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prvGo   <= '0;
      prvAddr <= '0;
      lvt     <= '0;
    end else begin
      prvGo   <= curGo;
      prvAddr <= wrAddr;
      if (prvGo[1]) lvt[prvAddr[1]] <= 1'b1;
      if (prvGo[0]) lvt[prvAddr[0]] <= 1'b0;
    end
  end

  assign stb.cur = curGo;
  assign stb.prv = prvGo;

  for (genvar r = 0; r < RD_PORTS; r++) begin : gRdCtl
    always_comb begin
      rdCtl[r].row = lvt[rdAddr[r]];
      if (rdAddr[r] == '0)
        rdCtl[r].src = SEL_ZERO;
      else if (curGo[1] && wrAddr[1] == rdAddr[r])
        rdCtl[r].src = SEL_CUR1;
      else if (curGo[0] && wrAddr[0] == rdAddr[r])
        rdCtl[r].src = SEL_CUR0;
      else if (prvGo[1] && prvAddr[1] == rdAddr[r])
        rdCtl[r].src = SEL_PRV1;
      else if (prvGo[0] && prvAddr[0] == rdAddr[r])
        rdCtl[r].src = SEL_PRV0;
      else
        rdCtl[r].src = SEL_BANK;
    end
  end
endmodule

// File: rtl/rfDatapath.sv
module rfDatapath
  import rfPkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int DW       = 32,
  parameter int RD_PORTS = 5,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wrStb_t                        stb,
  input  logic [WR_PORTS-1:0][AW-1:0]   wrAddr,
  input  logic [WR_PORTS-1:0][DW-1:0]   wrData,
  input  logic [RD_PORTS-1:0][AW-1:0]   rdAddr,
  input  rdCtl_t [RD_PORTS-1:0]         rdCtl,
  output logic [RD_PORTS-1:0][DW-1:0]   rdData
);
  logic [WR_PORTS-1:0][DW-1:0]               prvData;
  logic [WR_PORTS-1:0][RD_PORTS-1:0][DW-1:0] bankRd;

  always_ff @(posedge clk) begin
    if (!rstN) prvData <= '0;
    else       prvData <= wrData;
  end

  for (genvar w = 0; w < WR_PORTS; w++) begin : gRow
    for (genvar r = 0; r < RD_PORTS; r++) begin : gCol
      rfBank #(.DEPTH(DEPTH), .DW(DW)) uBank (
        .clk  (clk),
        .rstN (rstN),
        .we   (stb.cur[w]),
        .wa   (wrAddr[w]),
        .wd   (wrData[w]),
        .ra   (rdAddr[r]),
        .rd   (bankRd[w][r])
      );
    end
  end

  for (genvar r = 0; r < RD_PORTS; r++) begin : gMux
    always_comb begin
      case (rdCtl[r].src)
        SEL_ZERO: rdData[r] = '0;
        SEL_CUR0: rdData[r] = wrData[0];
        SEL_CUR1: rdData[r] = wrData[1];
        SEL_PRV0: rdData[r] = prvData[0];
        SEL_PRV1: rdData[r] = prvData[1];
        default:  rdData[r] = bankRd[rdCtl[r].row][r];
      endcase
    end
  end
endmodule

// File: rtl/regFileMp.sv
module regFileMp
  import rfPkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int DW         = 32,
  parameter int RD_PORTS   = 4,
  parameter bit DEBUG_PORT = 1'b1,
  localparam int AW        = $clog2(DEPTH),
  localparam int TOTAL_RD  = RD_PORTS + (DEBUG_PORT ? 1 : 0)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  wrEn,
  input  logic [1:0][AW-1:0]          wrAddr,
  input  logic [1:0][DW-1:0]          wrData,
  input  logic [RD_PORTS-1:0][AW-1:0] rdAddr,
  output logic [RD_PORTS-1:0][DW-1:0] rdData,
  input  logic [AW-1:0]               dbgAddr,
  output logic [DW-1:0]               dbgData
);
  logic [TOTAL_RD-1:0][AW-1:0] allAddr;
  logic [TOTAL_RD-1:0][DW-1:0] allData;
  rdCtl_t [TOTAL_RD-1:0]       rdCtl;
  wrStb_t                      stb;

  assign allAddr[RD_PORTS-1:0] = rdAddr;
  assign rdData = allData[RD_PORTS-1:0];

  if (DEBUG_PORT) begin : gDbg
    assign allAddr[RD_PORTS] = dbgAddr;
    assign dbgData = allData[RD_PORTS];
  end else begin : gNoDbg
    assign dbgData = '0;
  end

  rfControl #(.DEPTH(DEPTH), .RD_PORTS(TOTAL_RD)) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (allAddr),
    .stb    (stb),
    .rdCtl  (rdCtl)
  );

  rfDatapath #(.DEPTH(DEPTH), .DW(DW), .RD_PORTS(TOTAL_RD)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (allAddr),
    .rdCtl  (rdCtl),
    .rdData (allData)
  );
endmodule

// File: rtl/regFileMpChk.sv
module regFileMpChk
  import rfPkg::*;
#(
  parameter int AW         = 5,
  parameter int DW         = 32,
  parameter int RD_PORTS   = 4,
  parameter bit DEBUG_PORT = 1'b1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [1:0]                  wrEn,
  input logic [1:0][AW-1:0]          wrAddr,
  input logic [1:0][DW-1:0]          wrData,
  input logic [RD_PORTS-1:0][AW-1:0] rdAddr,
  input logic [RD_PORTS-1:0][DW-1:0] rdData,
  input logic [AW-1:0]               dbgAddr,
  input logic [DW-1:0]               dbgData,
  input wrStb_t                      stb
);
  a_r2_zero_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr[0] == '0) |-> (rdData[0] == '0));

  a_r3_write_through: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn[1] && wrAddr[1] == rdAddr[0] && rdAddr[0] != '0) |-> (rdData[0] == wrData[1]));

  a_r6_port1_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn == 2'b11 && wrAddr[0] == wrAddr[1] && wrAddr[0] == rdAddr[1] && rdAddr[1] != '0)
    |-> (rdData[1] == wrData[1]));

  a_r4_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn[0]) && $past(wrAddr[0]) != '0 &&
     !($past(wrEn[1]) && $past(wrAddr[1]) == $past(wrAddr[0])) &&
     rdAddr[2] == $past(wrAddr[0]) && wrEn == 2'b00)
    |-> (rdData[2] == $past(wrData[0])));

  a_r5_distinct_writes: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cur == 2'b11) |-> (wrAddr[0] != wrAddr[1]));

  if (DEBUG_PORT) begin : gDbgChk
    a_r7_debug_agrees: assert property (@(posedge clk) disable iff (!rstN)
      (rdAddr[3] == dbgAddr) |-> (rdData[3] == dbgData));
  end
endmodule

bind regFileMp regFileMpChk #(
  .AW(AW), .DW(DW), .RD_PORTS(RD_PORTS), .DEBUG_PORT(DEBUG_PORT)
) chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .dbgAddr(dbgAddr), .dbgData(dbgData),
  .stb(stb)
);

// File: tb/tb_regFileMp.sv
module tb_regFileMp;
  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       wrEn = '0;
  logic [1:0][4:0]  wrAddr = '0;
  logic [1:0][31:0] wrData = '0;
  logic [3:0][4:0]  rdAddr = '0;
  logic [3:0][31:0] rdData;
  logic [4:0]       dbgAddr = '0;
  logic [31:0]      dbgData;

  int vectors = 0;
  int fails = 0;
  logic [31:0] model [32];

  always #5 clk = ~clk;

  regFileMp dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  function automatic logic [31:0] expect_of(input logic [4:0] a);
    if (a == 0) return 32'h0;
    if (wrEn[1] && wrAddr[1] == a) return wrData[1];
    if (wrEn[0] && wrAddr[0] == a) return wrData[0];
    return model[a];
  endfunction

  task automatic check_one(input string tag, input int p, input logic [4:0] a,
                           input logic [31:0] act);
    logic [31:0] e;
    e = expect_of(a);
    vectors++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s port%0d addr=%0d actual=%h expected=%h", tag, p, a, act, e);
    end
  endtask

  // drive at the falling edge, compare before the rising edge, update model after it
  task automatic cycle(input string tag,
                       input logic [1:0] we, input logic [4:0] a0, input logic [31:0] d0,
                       input logic [4:0] a1, input logic [31:0] d1,
                       input logic [4:0] r0, input logic [4:0] r1, input logic [4:0] r2,
                       input logic [4:0] r3, input logic [4:0] rd);
    @(negedge clk);
    wrEn = we; wrAddr[0] = a0; wrData[0] = d0; wrAddr[1] = a1; wrData[1] = d1;
    rdAddr[0] = r0; rdAddr[1] = r1; rdAddr[2] = r2; rdAddr[3] = r3; dbgAddr = rd;
    #1;
    for (int p = 0; p < 4; p++) check_one(tag, p, rdAddr[p], rdData[p]);
    check_one(tag, 4, dbgAddr, dbgData);
    @(posedge clk);
    if (wrEn[0] && wrAddr[0] != 0) model[wrAddr[0]] = wrData[0];
    if (wrEn[1] && wrAddr[1] != 0) model[wrAddr[1]] = wrData[1];
  endtask

  task automatic idle_read(input string tag, input logic [4:0] r0, input logic [4:0] r1,
                           input logic [4:0] r2, input logic [4:0] r3, input logic [4:0] rd);
    cycle(tag, 2'b00, 5'd0, 32'h0, 5'd0, 32'h0, r0, r1, r2, r3, rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every register reads zero after reset
    for (int s = 0; s < 7; s++)
      idle_read("R1", 5'((s*5) % 32), 5'((s*5+1) % 32), 5'((s*5+2) % 32),
                5'((s*5+3) % 32), 5'((s*5+4) % 32));

    // R2: writes to register 0 are discarded
    cycle("R2", 2'b11, 5'd0, 32'hDEAD0000, 5'd0, 32'hBEEF0000, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0);
    for (int s = 0; s < 3; s++) idle_read("R2", 5'd0, 5'd0, 5'd0, 5'd0, 5'd0);

    // R3: same-cycle write-through on each port
    cycle("R3", 2'b01, 5'd5, 32'hA5A5_0005, 5'd0, 32'h0, 5'd5, 5'd9, 5'd5, 5'd9, 5'd5);
    cycle("R3", 2'b10, 5'd0, 32'h0, 5'd9, 32'hB9B9_0009, 5'd9, 5'd5, 5'd9, 5'd5, 5'd9);

    // R4: readable in the next cycle and beyond
    for (int s = 0; s < 4; s++) idle_read("R4", 5'd5, 5'd9, 5'd5, 5'd9, 5'd5);

    // R5: two distinct registers in one cycle
    cycle("R5", 2'b11, 5'd10, 32'h1010_1010, 5'd11, 32'h1111_1111,
          5'd10, 5'd11, 5'd10, 5'd11, 5'd10);
    for (int s = 0; s < 3; s++) idle_read("R5", 5'd10, 5'd11, 5'd11, 5'd10, 5'd11);

    // R6: same register on both ports, port 1 wins
    cycle("R6", 2'b11, 5'd12, 32'h0C0C_0000, 5'd12, 32'hD12D_1111,
          5'd12, 5'd12, 5'd12, 5'd12, 5'd12);
    for (int s = 0; s < 4; s++) idle_read("R6", 5'd12, 5'd12, 5'd0, 5'd12, 5'd12);

    // R8: back-to-back rewrites, port 1 then port 0, then port 0 then port 1
    cycle("R8", 2'b10, 5'd0, 32'h0, 5'd13, 32'hE000_0013, 5'd13, 5'd13, 5'd13, 5'd13, 5'd13);
    cycle("R8", 2'b01, 5'd13, 32'hF000_0013, 5'd0, 32'h0, 5'd13, 5'd13, 5'd13, 5'd13, 5'd13);
    cycle("R8", 2'b01, 5'd14, 32'h1400_0000, 5'd0, 32'h0, 5'd13, 5'd14, 5'd13, 5'd14, 5'd13);
    cycle("R8", 2'b10, 5'd0, 32'h0, 5'd14, 32'h1400_1111, 5'd13, 5'd14, 5'd13, 5'd14, 5'd14);
    cycle("R8", 2'b01, 5'd14, 32'h1400_2222, 5'd0, 32'h0, 5'd14, 5'd13, 5'd14, 5'd13, 5'd14);
    for (int s = 0; s < 4; s++) idle_read("R8", 5'd13, 5'd14, 5'd13, 5'd14, 5'd14);

    // R9: disabled ports change nothing
    cycle("R9", 2'b00, 5'd5, 32'h9999_9999, 5'd9, 32'h8888_8888, 5'd5, 5'd9, 5'd5, 5'd9, 5'd5);
    for (int s = 0; s < 3; s++) idle_read("R9", 5'd5, 5'd9, 5'd12, 5'd13, 5'd9);

    // R7: independent ports under dense random traffic with frequent collisions
    for (int s = 0; s < 400; s++)
      cycle("R7", 2'($urandom), 5'($urandom % 8), $urandom, 5'($urandom % 8), $urandom,
            5'($urandom % 8), 5'($urandom % 8), 5'($urandom % 8), 5'($urandom % 8),
            5'($urandom % 8));
    for (int s = 0; s < 8; s++)
      idle_read("R7", 5'(s), 5'(7-s), 5'(s), 5'((s+3) % 8), 5'((s+5) % 8));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule